// File: doc/BRIEF.md
# Interlocked Shared-Line Bus Read Master

This block is the requesting side of a clockless (asynchronous) bus on which address and data share one set of lines. A local client hands it a read command made of a start address and a word count. The block first asks an external arbiter for the bus and waits for the grant. It then runs one address handshake, followed by one data handshake per word. When the last word is done it gives the bus back. Each edge of every handshake is interlocked: the master moves only after it has seen the slave's previous edge.

Every input that comes from the bus passes through a two-flop synchroniser before the controller looks at it. This covers the grant, the slave's acknowledge, the slave's data-ready and the shared lines. The client side uses two valid/ready streams. Commands flow in on one. Words flow out on the other, and the client may stall it at any time. While the client stalls, the master keeps the slave's data-ready pending and withholds its own acknowledge. Because of this, no word is ever dropped or buffered beyond a single holding register. A one-cycle done pulse marks the moment the bus request is withdrawn.

Top module: `amb_read_master`

## Requirements
- R1: After reset, bus_req, ad_oe, bus_rd, bus_ack, rd_valid and done are all 0, and cmd_ready is 1.
- R2: ad_oe, bus_rd and bus_ack are only ever 1 while bus_req is 1 and the bus has been granted.
- R3: In the address phase, ad_out carries the command's start address with ad_oe = 1 for at least one cycle before bus_rd rises. ad_out holds that address unchanged at the rising edge of bus_rd.
- R4: bus_rd stays 1 until the synchronised slave acknowledge is seen. In the cycle after that, bus_rd and ad_oe are both 0. No data handshake begins until the slave acknowledge has dropped.
- R5: ad_oe is 0 for the whole of every data phase, so the slave can drive the shared lines.
- R6: bus_ack rises only after the word captured on the shared lines has been accepted by the client (rd_valid and rd_ready both 1 in the previous cycle).
- R7: Once bus_ack is 1, it stays 1 as long as the synchronised slave data-ready is 1.
- R8: A command with length field L produces exactly L+1 words on rd_data, in bus order, with exactly one address phase.
- R9: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data holds its value.
- R10: bus_req stays 1 from command acceptance until the last data acknowledge has dropped. It then falls in the same cycle as a one-cycle done pulse.
- R11: cmd_ready is 0 while a transfer is in progress. A cmd_valid presented during that time is ignored: no extra address phase follows, and bus_req is 0 after done.
- R12: The length field encodes words minus one, so the all-ones value of LEN_W bits (15 at the default width) yields 2^LEN_W = 16 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Client read command offered |
| cmd_ready | output | 1 | Master idle, command taken this cycle if offered |
| cmd_addr | input | BUS_W | Start address of the read |
| cmd_len | input | LEN_W | Number of words minus one |
| rd_valid | output | 1 | Captured word available |
| rd_ready | input | 1 | Client accepts the word |
| rd_data | output | BUS_W | Captured word |
| done | output | 1 | One-cycle pulse when the bus is released |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter (asynchronous) |
| ad_out | output | BUS_W | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines (0 = high impedance) |
| ad_in | input | BUS_W | Shared lines as seen by the master |
| bus_rd | output | 1 | Read strobe of the address phase |
| bus_ack | output | 1 | Master acknowledge of a data word |
| slv_ack | input | 1 | Slave acknowledge of the address |
| slv_drdy | input | 1 | Slave data-ready |

## Verification
The hardest case to reach is a client stall that lands inside a data phase. In that case the slave's data-ready stays raised, the captured word waits in the holding register, and the master must keep its acknowledge low for many cycles without losing or repeating the word. The bench reaches it with ready patterns on the client side that leave rd_ready low for up to eight cycles in a row. It combines these with a bus slave model whose response delays vary per test, and with late grants from the arbiter. To show that a command offered during a transfer is ignored, the bench offers a conflicting command while the bus is busy. It then checks the address phase count, the word order and the idle bus_req after done.

// File: rtl/amb_pkg.sv
package amb_pkg;

  // Controller states: request, address handshake, per-word data handshake.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_ASETUP,
    ST_ARD,
    ST_AREL,
    ST_DWAIT,
    ST_DHOLD,
    ST_DACK,
    ST_DONE
  } amb_state_e;

  localparam int unsigned AMB_SYNC_STAGES = 2;

endpackage

// File: rtl/amb_sync.sv
module amb_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/amb_dp.sv
module amb_dp #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             dec,
  input  logic             capture,
  input  logic [BUS_W-1:0] data_s,
  input  logic             ad_oe,
  output logic [BUS_W-1:0] ad_out,
  output logic [BUS_W-1:0] rd_data,
  output logic             last
);

  logic [BUS_W-1:0] addr_q;
  logic [LEN_W-1:0] remain_q;
  logic [BUS_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
    end else if (load) begin
      addr_q   <= cmd_addr;
      remain_q <= cmd_len;
    end else if (dec) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (capture) word_q <= data_s;
  end

  assign ad_out  = ad_oe ? addr_q : '0;
  assign rd_data = word_q;
  assign last    = (remain_q == '0);

endmodule

// File: rtl/amb_ctrl.sv
module amb_ctrl
  import amb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic grant_s,
  input  logic ack_s,
  input  logic drdy_s,
  input  logic rd_ready,
  input  logic last,
  output logic cmd_ready,
  output logic bus_req,
  output logic ad_oe,
  output logic bus_rd,
  output logic bus_ack,
  output logic rd_valid,
  output logic done,
  output logic load,
  output logic capture,
  output logic dec
);

  amb_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    capture = 1'b0;
    dec     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        load    = 1'b1;
        state_d = ST_REQ;
      end
      ST_REQ:    if (grant_s) state_d = ST_ASETUP;
      ST_ASETUP: state_d = ST_ARD;
      ST_ARD:    if (ack_s) state_d = ST_AREL;
      ST_AREL:   if (!ack_s) state_d = ST_DWAIT;
      ST_DWAIT: if (drdy_s) begin
        capture = 1'b1;
        state_d = ST_DHOLD;
      end
      ST_DHOLD:  if (rd_ready) state_d = ST_DACK;
      ST_DACK: if (!drdy_s) begin
        if (last) state_d = ST_DONE;
        else begin
          dec     = 1'b1;
          state_d = ST_DWAIT;
        end
      end
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd_ready = (state_q == ST_IDLE);
    bus_req   = (state_q != ST_IDLE) && (state_q != ST_DONE);
    ad_oe     = (state_q == ST_ASETUP) || (state_q == ST_ARD);
    bus_rd    = (state_q == ST_ARD);
    bus_ack   = (state_q == ST_DACK);
    rd_valid  = (state_q == ST_DHOLD);
    done      = (state_q == ST_DONE);
  end

endmodule

// File: rtl/amb_read_master.sv
module amb_read_master
  import amb_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [BUS_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [BUS_W-1:0] rd_data,
  output logic             done,
  output logic             bus_req,
  input  logic             bus_grant,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  input  logic [BUS_W-1:0] ad_in,
  output logic             bus_rd,
  output logic             bus_ack,
  input  logic             slv_ack,
  input  logic             slv_drdy
);

  localparam int unsigned SYNC_W = BUS_W + 3;

  logic             grant_s;
  logic             ack_s;
  logic             drdy_s;
  logic [BUS_W-1:0] data_s;
  logic             load;
  logic             capture;
  logic             dec;
  logic             last;

  amb_sync #(
    .W      (SYNC_W),
    .STAGES (AMB_SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_grant, slv_ack, slv_drdy, ad_in}),
    .q     ({grant_s, ack_s, drdy_s, data_s})
  );

  amb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .grant_s   (grant_s),
    .ack_s     (ack_s),
    .drdy_s    (drdy_s),
    .rd_ready  (rd_ready),
    .last      (last),
    .cmd_ready (cmd_ready),
    .bus_req   (bus_req),
    .ad_oe     (ad_oe),
    .bus_rd    (bus_rd),
    .bus_ack   (bus_ack),
    .rd_valid  (rd_valid),
    .done      (done),
    .load      (load),
    .capture   (capture),
    .dec       (dec)
  );

  amb_dp #(
    .BUS_W (BUS_W),
    .LEN_W (LEN_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .cmd_addr (cmd_addr),
    .cmd_len  (cmd_len),
    .dec      (dec),
    .capture  (capture),
    .data_s   (data_s),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out),
    .rd_data  (rd_data),
    .last     (last)
  );

endmodule

// File: rtl/amb_checks.sv
module amb_checks #(
  parameter int unsigned BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [BUS_W-1:0] rd_data,
  input logic             done,
  input logic             bus_req,
  input logic [BUS_W-1:0] ad_out,
  input logic             ad_oe,
  input logic             bus_rd,
  input logic             bus_ack,
  input logic             grant_s,
  input logic             ack_s,
  input logic             drdy_s
);

  AST_NO_DRIVE_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe || bus_rd || bus_ack) |-> (bus_req && grant_s)); // R2

  AST_ADDR_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> ($past(ad_oe) && $stable(ad_out))); // R3

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !ack_s) |=> bus_rd); // R4

  AST_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ack_s) |=> (!bus_rd && !ad_oe)); // R4

  AST_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack || rd_valid) |-> !ad_oe); // R5

  AST_ACK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(rd_valid && rd_ready)); // R6

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && drdy_s) |=> bus_ack); // R7

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9

  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req); // R10

  AST_REQ_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> done); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cmd_ready); // R11

endmodule

bind amb_read_master amb_checks #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .bus_req   (bus_req),
  .ad_out    (ad_out),
  .ad_oe     (ad_oe),
  .bus_rd    (bus_rd),
  .bus_ack   (bus_ack),
  .grant_s   (grant_s),
  .ack_s     (ack_s),
  .drdy_s    (drdy_s)
);

// File: tb/amb_read_master_test.sv
module amb_read_master_test;

  localparam int BUS_W = 16;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [BUS_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic [BUS_W-1:0] rd_data;
  logic             done;
  logic             bus_req;
  logic             bus_grant = 1'b0;
  logic [BUS_W-1:0] ad_out;
  logic             ad_oe;
  logic [BUS_W-1:0] ad_in = '0;
  logic             bus_rd;
  logic             bus_ack;
  logic             slv_ack = 1'b0;
  logic             slv_drdy = 1'b0;

  always #10 clk = ~clk;

  amb_read_master #(.BUS_W(BUS_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .bus_req(bus_req),
    .bus_grant(bus_grant), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .bus_rd(bus_rd), .bus_ack(bus_ack), .slv_ack(slv_ack), .slv_drdy(slv_drdy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [BUS_W-1:0] exp_q[$];
  logic [BUS_W-1:0] exp_addr = '0;
  int  got_words = 0;
  int  addr_phases = 0;
  int  slv_dly = 0;
  int  gnt_dly = 0;
  int  rdy_mode = 0;
  bit  slv_drv = 0;
  bit  viol_r2 = 0;
  bit  viol_r5 = 0;
  bit  viol_r10 = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] word_of(input logic [BUS_W-1:0] a);
    return (a * 16'd3) ^ 16'h5A3C;
  endfunction

  // Arbiter model
  initial begin
    int gcnt = 0;
    forever begin
      @(negedge clk);
      if (!bus_req) begin
        bus_grant = 1'b0;
        gcnt = 0;
      end else if (!bus_grant) begin
        if (gcnt >= gnt_dly) bus_grant = 1'b1;
        else gcnt++;
      end
    end
  end

  // Bus slave model
  initial begin
    logic [BUS_W-1:0] base;
    int idx;
    forever begin
      @(negedge clk);
      if (bus_rd) begin
        chk(ad_oe, "R3 ad_oe at read", 32'(ad_oe), 1);
        chk(ad_out == exp_addr, "R3 address", 32'(ad_out), 32'(exp_addr));
        base = ad_out;
        addr_phases++;
        repeat (slv_dly) @(negedge clk);
        slv_ack = 1'b1;
        do @(negedge clk); while (bus_rd || ad_oe);
        repeat (slv_dly) @(negedge clk);
        slv_ack = 1'b0;
        idx = 0;
        forever begin
          repeat (slv_dly) @(negedge clk);
          ad_in = word_of(base + BUS_W'(idx));
          slv_drdy = 1'b1;
          slv_drv = 1'b1;
          do @(negedge clk); while (!bus_ack);
          repeat (slv_dly) @(negedge clk);
          slv_drdy = 1'b0;
          slv_drv = 1'b0;
          ad_in = 16'hDEAD;
          do @(negedge clk); while (bus_ack);
          idx++;
          if (!bus_req) break;
        end
      end
    end
  end

  // Protocol monitor at the bus pins
  initial begin
    logic prev_req = 1'b0;
    forever begin
      @(negedge clk);
      if ((ad_oe || bus_rd || bus_ack) && !bus_grant) viol_r2 = 1;
      if (ad_oe && slv_drv) viol_r5 = 1;
      if (prev_req && !bus_req && !done) viol_r10 = 1;
      prev_req = bus_req;
    end
  end

  // Scoreboard monitor on the word stream; also drives rd_ready
  initial begin
    int rcnt = 0;
    bit stalled = 0;
    logic [BUS_W-1:0] held = '0;
    logic [BUS_W-1:0] e;
    forever begin
      @(negedge clk);
      if (stalled)
        chk(rd_valid && rd_data == held, "R9 stall hold", 32'(rd_data), 32'(held));
      case (rdy_mode)
        0: rd_ready = 1'b1;
        1: rd_ready = (rcnt % 3) == 2;
        default: rd_ready = (rcnt % 9) == 8;
      endcase
      rcnt++;
      if (rd_valid && rd_ready) begin
        got_words++;
        if (exp_q.size() == 0) chk(0, "R8 unexpected word", 32'(rd_data), 0);
        else begin
          e = exp_q.pop_front();
          chk(rd_data == e, "R8 word", 32'(rd_data), 32'(e));
        end
      end
      stalled = rd_valid && !rd_ready;
      held = rd_data;
    end
  end

  task automatic run(input logic [BUS_W-1:0] addr, input logic [LEN_W-1:0] len,
                     input bit junk, input string tag);
    int cyc;
    for (int i = 0; i <= int'(len); i++) exp_q.push_back(word_of(addr + BUS_W'(i)));
    exp_addr = addr;
    got_words = 0;
    addr_phases = 0;
    @(negedge clk);
    chk(cmd_ready, {tag, " R11 idle ready"}, 32'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_addr = addr;
    cmd_len = len;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      if (junk && cyc >= 1 && cyc <= 4) begin
        cmd_valid = 1'b1;
        cmd_addr = 16'hBEEF;
        cmd_len = 4'd7;
        chk(!cmd_ready, {tag, " R11 busy"}, 32'(cmd_ready), 0);
      end else cmd_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(done, {tag, " watchdog"}, 32'(cyc), 0);
    chk(!bus_req, {tag, " R10 req low at done"}, 32'(bus_req), 0);
    chk(got_words == int'(len) + 1, {tag, " R8 R12 word count"}, 32'(got_words),
        32'(int'(len) + 1));
    chk(addr_phases == 1, {tag, " R8 address phases"}, 32'(addr_phases), 1);
    chk(exp_q.size() == 0, {tag, " R8 queue empty"}, 32'(exp_q.size()), 0);
    repeat (12) @(negedge clk);
    chk(!bus_req && cmd_ready, {tag, " R11 no extra transfer"}, 32'(bus_req), 0);
    chk(addr_phases == 1, {tag, " R11 no extra address"}, 32'(addr_phases), 1);
    chk(!viol_r2, {tag, " R2 drive only when granted"}, 32'(viol_r2), 0);
    chk(!viol_r5, {tag, " R5 lines released in data"}, 32'(viol_r5), 0);
    chk(!viol_r10, {tag, " R10 req held to done"}, 32'(viol_r10), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!bus_req && !ad_oe && !bus_rd && !bus_ack, "R1 bus idle in reset",
        {bus_req, ad_oe, bus_rd, bus_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !ad_oe && !bus_rd && !bus_ack && !rd_valid && !done,
        "R1 outputs after reset", {bus_req, ad_oe, bus_rd, bus_ack, rd_valid, done}, 0);
    chk(cmd_ready, "R1 cmd_ready after reset", 32'(cmd_ready), 1);

    rdy_mode = 0; slv_dly = 0; gnt_dly = 0;
    run(16'h0100, 4'd0, 0, "single");          // R3 R4 R6 R7
    rdy_mode = 1; slv_dly = 1;
    run(16'h2040, 4'd3, 0, "four_stall");      // R9
    rdy_mode = 0; slv_dly = 2; gnt_dly = 5;
    run(16'hFFF8, 4'd15, 0, "max_len");        // R12 with address wrap
    rdy_mode = 1; slv_dly = 0; gnt_dly = 2;
    run(16'h0A00, 4'd2, 1, "busy_cmd");        // R11
    rdy_mode = 2; slv_dly = 1; gnt_dly = 0;
    run(16'h3333, 4'd1, 0, "long_stall");      // R9 R6 R7
    rdy_mode = 2; slv_dly = 3; gnt_dly = 7;
    run(16'h7FFF, 4'd5, 1, "slow_all");        // R2 R5 R10

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule